// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Bank

This block is one bank of sixteen general-purpose pins behind a simple synchronous register bus. Each pin has a direction bit and an output bit. Software can change the outputs in three ways: replace all sixteen bits at once, raise chosen bits by writing ones to a set register, or lower chosen bits by writing ones to a clear register. A pair of hardware strobe vectors gives the same set and clear action to logic beside the bank. Because a write of ones to the set or clear register touches only the named bits, independent tasks can drive different pins without a read-modify-write.

Pin levels pass through a two-flop synchronizer before the input register and the edge detector see them. Each pin has its own rising-edge and falling-edge enables. An enabled edge sets a sticky per-pin interrupt bit, which software clears by writing one, and it also fires a single-cycle per-pin DMA request. A build-time mask makes chosen pins input-only: their output enable and output value are held low. Edge detection still runs on those pins.

The bus writes on the clock edge when `busWrEn` is high. Reads are combinational from `busAddr`. Register addresses are 4 bits wide and refer to 16-bit words.

Top module: `gpio_bank`

## Requirements
- R1: After reset, `pinOe`, `pinOut`, `irq` and `dmaEvt` are all zero and every readable register reads zero. Bit n of every register and port vector belongs to pin n. The direction register is at address 0; a 1 in bit n drives `pinOe[n]` high, making pin n an output.
- R2: A write to the output register at address 1 replaces all output bits at once. A read of address 1 returns the value driven on `pinOut`, not the sampled pin level.
- R3: Writing to the set register at address 2 drives high every output bit whose data bit is 1 and leaves bits written 0 unchanged. Address 2 reads as zero.
- R4: Writing to the clear register at address 3 drives low every output bit whose data bit is 1 and leaves bits written 0 unchanged. The `outSet`/`outClr` strobe ports act the same way. When a set and a clear for one bit meet in the same cycle, from the bus or the ports in any mix, the clear wins.
- R5: A direct write to the output register takes priority over any set or clear in the same cycle.
- R6: The input register at address 4 returns the pin levels after a two-flop synchronizer. A change on `pinIn` becomes readable after the second rising clock edge.
- R7: The rising-edge enable register (address 5) and the falling-edge enable register (address 6) are independent for each pin. An edge is found by comparing the synchronized level with its value one cycle earlier. An edge whose enable bit is 0 produces nothing.
- R8: An enabled edge sets bit n of the sticky status register at address 7. That bit drives `irq[n]`. Writing 1 to a status bit clears it, and writing 0 leaves it. If an edge and a clear hit the same bit in the same cycle, the bit stays set.
- R9: `dmaEvt[n]` is high for exactly one cycle for each enabled edge, in the same cycle that the status bit becomes set. This is the third rising clock edge after the pin changes.
- R10: Pins named in the `INPUT_ONLY_MASK` parameter (default bits 15 and 14) always have `pinOe` and `pinOut` low. Direction and output writes to those bits are ignored, and those bits read back as zero.
- R11: Edge detection works whatever the pin's direction, including on input-only pins.
- R12: Addresses 8 to 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 4 | Register word address |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for `busAddr` (combinational) |
| outSet | input | 16 | Hardware strobe: drive the named output bits high |
| outClr | input | 16 | Hardware strobe: drive the named output bits low |
| pinIn | input | 16 | Asynchronous pin levels |
| pinOut | output | 16 | Driven output values |
| pinOe | output | 16 | Output enables (1 = output) |
| irq | output | 16 | Per-pin sticky interrupt |
| dmaEvt | output | 16 | Per-pin one-cycle DMA request |

## Verification
The bound checker tests five properties on every cycle:
- input-only pins never drive;
- a clear, whether from the bus or the ports, leaves its bits low one cycle later;
- a set leaves its bits high;
- a direct output write lands exactly, with the masked bits low;
- interrupt bits never fall without a status write, and every DMA pulse coincides with a set interrupt bit.

The rest can only be shown by the directed scenarios:
- the two-edge synchronizer latency;
- whether each edge enable is honoured or ignored;
- the one-cycle width of the DMA pulse;
- the edge-beats-clear race;
- the order of priority among a direct write, a clear and a set arriving together.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_ADDR_W = 4;

  localparam logic [REG_ADDR_W-1:0] REG_DIR  = 4'd0;
  localparam logic [REG_ADDR_W-1:0] REG_OUT  = 4'd1;
  localparam logic [REG_ADDR_W-1:0] REG_SET  = 4'd2;
  localparam logic [REG_ADDR_W-1:0] REG_CLR  = 4'd3;
  localparam logic [REG_ADDR_W-1:0] REG_IN   = 4'd4;
  localparam logic [REG_ADDR_W-1:0] REG_RISE = 4'd5;
  localparam logic [REG_ADDR_W-1:0] REG_FALL = 4'd6;
  localparam logic [REG_ADDR_W-1:0] REG_STAT = 4'd7;

  typedef enum logic [2:0] {
    RD_ZERO, RD_DIR, RD_OUT, RD_IN, RD_RISE, RD_FALL, RD_STAT
  } rdSel_e;

  typedef struct packed {
    logic wrDir;
    logic wrOut;
    logic wrSet;
    logic wrClr;
    logic wrRise;
    logic wrFall;
    logic wrStat;
  } regStrobe_t;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) chain[0] <= '0;
          else       chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/gpio_bank_ctl.sv
module gpio_bank_ctl
  import gpio_bank_pkg::*;
(
  input  logic                  busWrEn,
  input  logic [REG_ADDR_W-1:0] busAddr,
  output regStrobe_t            strobe,
  output rdSel_e                rdSel
);
  always_comb begin
    strobe = '0;
    rdSel  = RD_ZERO;
    case (busAddr)
      REG_DIR:  begin strobe.wrDir  = busWrEn; rdSel = RD_DIR;  end
      REG_OUT:  begin strobe.wrOut  = busWrEn; rdSel = RD_OUT;  end
      REG_SET:  begin strobe.wrSet  = busWrEn; end
      REG_CLR:  begin strobe.wrClr  = busWrEn; end
      REG_IN:   begin rdSel = RD_IN; end
      REG_RISE: begin strobe.wrRise = busWrEn; rdSel = RD_RISE; end
      REG_FALL: begin strobe.wrFall = busWrEn; rdSel = RD_FALL; end
      REG_STAT: begin strobe.wrStat = busWrEn; rdSel = RD_STAT; end
      default:  begin rdSel = RD_ZERO; end
    endcase
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int                   PIN_COUNT       = 16,
  parameter logic [PIN_COUNT-1:0] INPUT_ONLY_MASK = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strobe,
  input  rdSel_e               rdSel,
  input  logic [PIN_COUNT-1:0] wdata,
  input  logic [PIN_COUNT-1:0] setPort,
  input  logic [PIN_COUNT-1:0] clrPort,
  input  logic [PIN_COUNT-1:0] pinSync,
  output logic [PIN_COUNT-1:0] rdData,
  output logic [PIN_COUNT-1:0] dirQ,
  output logic [PIN_COUNT-1:0] outQ,
  output logic [PIN_COUNT-1:0] statQ,
  output logic [PIN_COUNT-1:0] dmaQ
);
  logic [PIN_COUNT-1:0] setVec, clrVec, ackVec;
  logic [PIN_COUNT-1:0] riseEn, fallEn, prevQ, edgeHit;

  assign setVec = (strobe.wrSet ? wdata : '0) | setPort;
  assign clrVec = (strobe.wrClr ? wdata : '0) | clrPort;
  assign ackVec = strobe.wrStat ? wdata : '0;

  genvar i;
  generate
    for (i = 0; i < PIN_COUNT; i++) begin : g_pin
      if (INPUT_ONLY_MASK[i]) begin : g_inOnly
        assign dirQ[i] = 1'b0;
        assign outQ[i] = 1'b0;
      end else begin : g_io
        logic dirBit, outBit;
        always_ff @(posedge clk) begin
          if (!rstN) begin
            dirBit <= 1'b0;
            outBit <= 1'b0;
          end else begin
            if (strobe.wrDir) dirBit <= wdata[i];
            if (strobe.wrOut)    outBit <= wdata[i];
            else if (clrVec[i])  outBit <= 1'b0;
            else if (setVec[i])  outBit <= 1'b1;
          end
        end
        assign dirQ[i] = dirBit;
        assign outQ[i] = outBit;
      end
    end
  endgenerate

  assign edgeHit = (pinSync & ~prevQ & riseEn) | (~pinSync & prevQ & fallEn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      riseEn <= '0;
      fallEn <= '0;
      prevQ  <= '0;
      statQ  <= '0;
      dmaQ   <= '0;
    end else begin
      if (strobe.wrRise) riseEn <= wdata;
      if (strobe.wrFall) fallEn <= wdata;
      prevQ <= pinSync;
      statQ <= (statQ & ~ackVec) | edgeHit;
      dmaQ  <= edgeHit;
    end
  end

  always_comb begin
    case (rdSel)
      RD_DIR:  rdData = dirQ;
      RD_OUT:  rdData = outQ;
      RD_IN:   rdData = pinSync;
      RD_RISE: rdData = riseEn;
      RD_FALL: rdData = fallEn;
      RD_STAT: rdData = statQ;
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int                   PIN_COUNT       = 16,
  parameter logic [PIN_COUNT-1:0] INPUT_ONLY_MASK = 16'hC000,
  parameter int                   SYNC_STAGES     = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrEn,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [PIN_COUNT-1:0]  busWdata,
  output logic [PIN_COUNT-1:0]  busRdata,
  input  logic [PIN_COUNT-1:0]  outSet,
  input  logic [PIN_COUNT-1:0]  outClr,
  input  logic [PIN_COUNT-1:0]  pinIn,
  output logic [PIN_COUNT-1:0]  pinOut,
  output logic [PIN_COUNT-1:0]  pinOe,
  output logic [PIN_COUNT-1:0]  irq,
  output logic [PIN_COUNT-1:0]  dmaEvt
);
  regStrobe_t           strobe;
  rdSel_e               rdSel;
  logic [PIN_COUNT-1:0] pinSync;

  gpio_bank_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(pinIn), .syncOut(pinSync)
  );

  gpio_bank_ctl u_ctl (
    .busWrEn(busWrEn), .busAddr(busAddr), .strobe(strobe), .rdSel(rdSel)
  );

  gpio_bank_dp #(.PIN_COUNT(PIN_COUNT), .INPUT_ONLY_MASK(INPUT_ONLY_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel), .wdata(busWdata),
    .setPort(outSet), .clrPort(outClr), .pinSync(pinSync), .rdData(busRdata),
    .dirQ(pinOe), .outQ(pinOut), .statQ(irq), .dmaQ(dmaEvt)
  );
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int                   PIN_COUNT       = 16,
  parameter logic [PIN_COUNT-1:0] INPUT_ONLY_MASK = 16'hC000
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busWrEn,
  input logic [REG_ADDR_W-1:0] busAddr,
  input logic [PIN_COUNT-1:0]  busWdata,
  input logic [PIN_COUNT-1:0]  outClr,
  input logic [PIN_COUNT-1:0]  pinOut,
  input logic [PIN_COUNT-1:0]  pinOe,
  input logic [PIN_COUNT-1:0]  irq,
  input logic [PIN_COUNT-1:0]  dmaEvt
);
  p_input_only_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOe | pinOut) & INPUT_ONLY_MASK) == '0);

  p_set_drives_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == REG_SET && outClr == '0)
    |=> ((pinOut & $past(busWdata) & ~INPUT_ONLY_MASK) == ($past(busWdata) & ~INPUT_ONLY_MASK)));

  p_bus_clear_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == REG_CLR) |=> ((pinOut & $past(busWdata)) == '0));

  p_port_clear_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((|outClr) && !(busWrEn && busAddr == REG_OUT)) |=> ((pinOut & $past(outClr)) == '0));

  p_direct_write_wins_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == REG_OUT) |=> (pinOut == ($past(busWdata) & ~INPUT_ONLY_MASK)));

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == REG_STAT) |=> ((irq & $past(irq)) == $past(irq)));

  p_dma_with_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dmaEvt & ~irq) == '0);
endmodule

bind gpio_bank gpio_bank_chk #(.PIN_COUNT(PIN_COUNT), .INPUT_ONLY_MASK(INPUT_ONLY_MASK)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .busWdata(busWdata),
  .outClr(outClr), .pinOut(pinOut), .pinOe(pinOe), .irq(irq), .dmaEvt(dmaEvt)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [15:0] outSet = '0, outClr = '0, pinIn = '0;
  logic [15:0] pinOut, pinOe, irq, dmaEvt;
  int checks = 0, errors = 0;

  gpio_bank uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .outSet(outSet), .outClr(outClr), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irq(irq), .dmaEvt(dmaEvt)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic strobeOut(input logic [15:0] s, input logic [15:0] c,
                           input logic busOn, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    outSet = s; outClr = c; busWrEn = busOn; busAddr = a; busWdata = d;
    @(negedge clk);
    outSet = '0; outClr = '0; busWrEn = 1'b0;
  endtask

  task automatic testReset();
    logic [15:0] v;
    check("R1 pinOe reset", pinOe, 16'h0);
    check("R1 pinOut reset", pinOut, 16'h0);
    check("R1 irq reset", irq, 16'h0);
    check("R1 dmaEvt reset", dmaEvt, 16'h0);
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], v);
      check(a < 8 ? "R1 register reset" : "R12 unmapped read", v, 16'h0);
    end
  endtask

  task automatic testDirOut();
    logic [15:0] v;
    wr(4'd0, 16'hFFFF);
    check("R1/R10 pinOe after dir write", pinOe, 16'h3FFF);
    rd(4'd0, v); check("R10 dir readback", v, 16'h3FFF);
    wr(4'd1, 16'hA5A5);
    check("R2/R10 pinOut direct write", pinOut, 16'h25A5);
    rd(4'd1, v); check("R2 out readback is driven value", v, 16'h25A5);
    rd(4'd9, v); check("R12 unmapped after writes", v, 16'h0);
  endtask

  task automatic testSetClr();
    logic [15:0] v;
    wr(4'd1, 16'h0000);
    wr(4'd2, 16'h0011); check("R3 set bits", pinOut, 16'h0011);
    wr(4'd2, 16'h0100); check("R3 zeros leave bits", pinOut, 16'h0111);
    rd(4'd2, v); check("R3 set reads zero", v, 16'h0);
    wr(4'd3, 16'h0001); check("R4 clear bit", pinOut, 16'h0110);
    wr(4'd3, 16'h0000); check("R4 zeros leave bits", pinOut, 16'h0110);
    strobeOut(16'h00F0, 16'h0030, 1'b0, 4'd0, 16'h0);
    check("R4 port clear beats set", pinOut, 16'h01C0);
    strobeOut(16'hC000, 16'h0000, 1'b0, 4'd0, 16'h0);
    check("R10 set on input-only ignored", pinOut, 16'h01C0);
    strobeOut(16'hFFFF, 16'hFFFF, 1'b1, 4'd1, 16'h1234);
    check("R5 direct write beats set/clear", pinOut, 16'h1234);
    strobeOut(16'h0000, 16'h0004, 1'b1, 4'd2, 16'h0004);
    check("R4 port clear beats bus set", pinOut, 16'h1230);
  endtask

  task automatic testSync();
    logic [15:0] v;
    @(negedge clk); pinIn = 16'h0008;
    @(negedge clk); rd(4'd4, v); check("R6 input after one edge", v, 16'h0000);
    @(negedge clk); rd(4'd4, v); check("R6 input after two edges", v, 16'h0008);
    rd(4'd1, v); check("R2 out readback ignores pin", v, 16'h1230);
    @(negedge clk); pinIn = 16'h0000;
    repeat (4) @(negedge clk);
  endtask

  task automatic pinsAndWait(input logic [15:0] p);
    @(negedge clk); pinIn = p;
    repeat (3) @(negedge clk);
  endtask

  task automatic testEdges();
    logic [15:0] v;
    wr(4'd5, 16'h8003);
    wr(4'd6, 16'h0002);
    @(negedge clk); pinIn = 16'h0005;
    repeat (2) @(negedge clk);
    check("R9 no pulse before third edge", dmaEvt, 16'h0);
    @(negedge clk);
    check("R7/R9 rise pulse, disabled pin silent", dmaEvt, 16'h0001);
    check("R8/R11 irq set on output pin", irq, 16'h0001);
    @(negedge clk);
    check("R9 pulse lasts one cycle", dmaEvt, 16'h0);
    check("R8 irq sticky", irq, 16'h0001);
    pinsAndWait(16'h0004);
    check("R7 disabled fall ignored", dmaEvt, 16'h0);
    pinsAndWait(16'h0006);
    check("R7 rise on pin1", dmaEvt, 16'h0002);
    pinsAndWait(16'h0004);
    check("R7 fall on pin1", dmaEvt, 16'h0002);
    check("R8 irq bits", irq, 16'h0003);
    wr(4'd7, 16'h0000); check("R8 write zero leaves status", irq, 16'h0003);
    wr(4'd7, 16'h0001); check("R8 write one clears", irq, 16'h0002);
    rd(4'd7, v); check("R8 status readback", v, 16'h0002);
    @(negedge clk); pinIn = 16'h0006;
    @(negedge clk);
    wr(4'd7, 16'h0002);
    check("R8 edge beats clear", irq, 16'h0002);
    pinsAndWait(16'h8006);
    check("R10/R11 edge on input-only pin", irq, 16'h8002);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h1, 16'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDirOut();
    testSetClr();
    testSync();
    testEdges();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule